// File: doc/BRIEF.md
# Fuse Array Word Reader

This controller sits between a 32-bit register bus and a one-time-programmable fuse array of 32 words, each 32 bits wide. It lets software read the array in one of two ways. In manual mode, a control register passes its bits straight to the pins of the fuse macro, so software sequences the read itself. A data register follows the macro output on every clock where the manual strobe bit is set.

In automatic mode, one write to the auto-control register starts a hardware sequence that reads a single word. The sequence has a setup phase, a strobe pulse of fixed length, a capture cycle, a hold phase and a standby cycle. It then raises a sticky completion flag, which software clears by writing a one. While the sequencer runs it owns the macro pins. Control-register writes and further start requests are dropped during that time. A word address outside the array finishes at once with zero data and never strobes the macro.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x0000_0021, the pins are in standby (power-down and select-bar high, all other pins and the address low), the status register (0x18) reads 0 and the auto data register (0x20) reads 0.
- R2: When the sequencer is idle, control-register bits drive the pins directly: bit 0 select-bar, bit 1 strobe, bit 2 load, bit 3 program-enable-bar, bit 5 power-down, bit 7 sense-bar, bit 9 strobe-shift select, and bits 25:16 the word address.
- R3: The manual data register (offset 0x04) takes the macro output on each clock edge where the sequencer is idle and control bit 1 is set, and it keeps its value otherwise.
- R4: A write to the auto-control register (0x24) with bits 0 and 1 both set starts one word read at the address in bits 25:16. A write with only one of the two bits set starts nothing. The register reads back the last accepted address in bits 25:16.
- R5: During an automatic read, select-bar is low and load and program-enable-bar are high for a setup phase before the strobe. The strobe then stays high for STRB_CYC cycles plus one capture cycle, and power-down stays low.
- R6: An automatic read of a valid address leaves the addressed fuse word in the auto data register (0x20) and sets status bit 0 within 500 cycles (5 us at 100 MHz) of the start write.
- R7: Status bit 0 is sticky. Writing a 1 to bit 0 of 0x18 clears it, and writing 0 leaves it set.
- R8: A start request that arrives while a sequence is running is ignored. The running read completes with its own address and data.
- R9: Control-register writes made while the sequencer owns the pins are discarded.
- R10: A start with an address of 32 or higher never raises the strobe, returns zero data and still sets status bit 0. Address 31 is read normally.
- R11: During the standby and finish cycles of a sequence the pins show the standby pattern. Once the sequence ends, pin control returns to the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_sel_n | output | 1 | Macro select, active low |
| fuse_strobe | output | 1 | Macro read strobe |
| fuse_load | output | 1 | Macro load enable |
| fuse_prog_n | output | 1 | Program enable, active low |
| fuse_pwrdn | output | 1 | Macro power-down |
| fuse_sense_n | output | 1 | Sense control, active low |
| fuse_strb_shift | output | 1 | Strobe shift select |
| fuse_addr | output | 10 | Word address to the macro |
| fuse_q | input | 32 | Word output from the macro |

## Verification
The assertions take for granted that the bus writes one register per cycle, and that the macro output only carries meaning while the strobe is high. They also assume software never tries to drive a strobe through the control register during an automatic run. The bench writes one register at a time and keeps the control register in standby while it starts automatic reads. Its fuse model returns a distinctive all-ones word for out-of-range addresses, so a strobe at such an address would show up in the data. The overlapping start and the locked control write are each issued while the sequence is still in its setup phase.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MDATA = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_ADATA = 8'h20;
  localparam logic [7:0] OFS_AUTO  = 8'h24;

  localparam logic [31:0] CTRL_STANDBY = 32'h0000_0021;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_STRB, SQ_CAPT, SQ_HOLD, SQ_STBY, SQ_DONE
  } seq_state_t;

  typedef struct packed {
    logic       sel_n;
    logic       strobe;
    logic       load;
    logic       prog_n;
    logic       pwrdn;
    logic       sense_n;
    logic       strb_shift;
    logic [9:0] addr;
  } pin_bundle_t;

  function automatic pin_bundle_t pins_from_ctrl(input logic [31:0] c);
    pin_bundle_t p;
    p.sel_n      = c[0];
    p.strobe     = c[1];
    p.load       = c[2];
    p.prog_n     = c[3];
    p.pwrdn      = c[5];
    p.sense_n    = c[7];
    p.strb_shift = c[9];
    p.addr       = c[25:16];
    return p;
  endfunction

  function automatic pin_bundle_t standby_pins();
    pin_bundle_t p;
    p = '0;
    p.sel_n = 1'b1;
    p.pwrdn = 1'b1;
    return p;
  endfunction

  function automatic pin_bundle_t read_pins(input logic [9:0] a, input logic stb);
    pin_bundle_t p;
    p.sel_n      = 1'b0;
    p.strobe     = stb;
    p.load       = 1'b1;
    p.prog_n     = 1'b1;
    p.pwrdn      = 1'b0;
    p.sense_n    = 1'b1;
    p.strb_shift = 1'b1;
    p.addr       = a;
    return p;
  endfunction

  function automatic logic start_code(input logic [31:0] w);
    return w[0] & w[1];
  endfunction

  function automatic logic word_in_range(input logic [9:0] a, input int words);
    return int'(a) < words;
  endfunction

endpackage

// File: rtl/fuse_reg_file.sv
module fuse_reg_file
  import fuse_rd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy,
  input  logic          done_pulse,
  input  logic [DW-1:0] fuse_q,
  input  logic [DW-1:0] auto_data,
  input  logic [9:0]    auto_addr,
  output logic [DW-1:0] ctrl_q,
  output logic          ctrl_wr,
  output logic          start_req,
  output logic [9:0]    start_addr,
  output logic          clr_req,
  output logic          done_flag
);

  logic [DW-1:0] mdata_q;
  logic          wr_ctrl, wr_stat, wr_auto;

  assign wr_ctrl    = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_stat    = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign wr_auto    = bus_wr && (bus_addr == AW'(OFS_AUTO));
  assign ctrl_wr    = wr_ctrl;
  assign start_req  = wr_auto && start_code(bus_wdata);
  assign start_addr = bus_wdata[25:16];
  assign clr_req    = wr_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_STANDBY;
    end else if (wr_ctrl && !busy) begin
      ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdata_q <= '0;
    end else if (!busy && ctrl_q[1]) begin
      mdata_q <= fuse_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (done_pulse) begin
      done_flag <= 1'b1;
    end else if (clr_req) begin
      done_flag <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(OFS_CTRL):  bus_rdata = ctrl_q;
      AW'(OFS_MDATA): bus_rdata = mdata_q;
      AW'(OFS_STAT):  bus_rdata = {{(DW-1){1'b0}}, done_flag};
      AW'(OFS_ADATA): bus_rdata = auto_data;
      AW'(OFS_AUTO):  bus_rdata = {6'b0, auto_addr, 16'b0};
      default:        bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fuse_auto_seq.sv
module fuse_auto_seq
  import fuse_rd_pkg::*;
#(
  parameter int DW        = 32,
  parameter int WORDS     = 32,
  parameter int SETUP_CYC = 4,
  parameter int STRB_CYC  = 6,
  parameter int HOLD_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [9:0]    start_addr,
  input  logic [DW-1:0] fuse_q,
  output logic          busy,
  output logic          done_pulse,
  output logic          in_standby,
  output logic [9:0]    auto_addr,
  output logic [DW-1:0] auto_data,
  output pin_bundle_t   seq_pins
);

  localparam int MAX_CYC = (SETUP_CYC > STRB_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((STRB_CYC > HOLD_CYC) ? STRB_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  function automatic logic phase_last(input logic [CW-1:0] c, input int len);
    return int'(c) >= (len - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      auto_addr <= '0;
      auto_data <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start_req) begin
            auto_addr <= start_addr;
            if (word_in_range(start_addr, WORDS)) begin
              state <= SQ_SETUP;
            end else begin
              auto_data <= '0;
              state     <= SQ_DONE;
            end
          end
        end
        SQ_SETUP: begin
          if (phase_last(cnt, SETUP_CYC)) begin
            cnt   <= '0;
            state <= SQ_STRB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_STRB: begin
          if (phase_last(cnt, STRB_CYC)) begin
            cnt   <= '0;
            state <= SQ_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_CAPT: begin
          auto_data <= fuse_q;
          state     <= SQ_HOLD;
        end
        SQ_HOLD: begin
          if (phase_last(cnt, HOLD_CYC)) begin
            cnt   <= '0;
            state <= SQ_STBY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_STBY: state <= SQ_DONE;
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (state != SQ_IDLE);
  assign done_pulse = (state == SQ_DONE);
  assign in_standby = (state == SQ_STBY) || (state == SQ_DONE);

  always_comb begin
    case (state)
      SQ_SETUP, SQ_HOLD: seq_pins = read_pins(auto_addr, 1'b0);
      SQ_STRB, SQ_CAPT:  seq_pins = read_pins(auto_addr, 1'b1);
      default:           seq_pins = standby_pins();
    endcase
  end

endmodule

// File: rtl/fuse_pin_mux.sv
module fuse_pin_mux
  import fuse_rd_pkg::*;
(
  input  logic        busy,
  input  logic [31:0] ctrl_q,
  input  pin_bundle_t seq_pins,
  output pin_bundle_t pins
);

  always_comb begin
    if (busy) pins = seq_pins;
    else      pins = pins_from_ctrl(ctrl_q);
  end

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int WORDS     = 32,
  parameter int SETUP_CYC = 4,
  parameter int STRB_CYC  = 6,
  parameter int HOLD_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          fuse_sel_n,
  output logic          fuse_strobe,
  output logic          fuse_load,
  output logic          fuse_prog_n,
  output logic          fuse_pwrdn,
  output logic          fuse_sense_n,
  output logic          fuse_strb_shift,
  output logic [9:0]    fuse_addr,
  input  logic [DW-1:0] fuse_q
);

  logic          seq_busy, done_pulse, in_standby;
  logic          ctrl_wr, start_req, clr_req, done_flag;
  logic [9:0]    start_addr, auto_addr;
  logic [DW-1:0] ctrl_q, auto_data;
  pin_bundle_t   seq_pins, pins;

  fuse_reg_file #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (seq_busy),
    .done_pulse (done_pulse),
    .fuse_q     (fuse_q),
    .auto_data  (auto_data),
    .auto_addr  (auto_addr),
    .ctrl_q     (ctrl_q),
    .ctrl_wr    (ctrl_wr),
    .start_req  (start_req),
    .start_addr (start_addr),
    .clr_req    (clr_req),
    .done_flag  (done_flag)
  );

  fuse_auto_seq #(
    .DW(DW), .WORDS(WORDS), .SETUP_CYC(SETUP_CYC),
    .STRB_CYC(STRB_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .start_addr (start_addr),
    .fuse_q     (fuse_q),
    .busy       (seq_busy),
    .done_pulse (done_pulse),
    .in_standby (in_standby),
    .auto_addr  (auto_addr),
    .auto_data  (auto_data),
    .seq_pins   (seq_pins)
  );

  fuse_pin_mux u_mux (
    .busy     (seq_busy),
    .ctrl_q   (ctrl_q),
    .seq_pins (seq_pins),
    .pins     (pins)
  );

  assign fuse_sel_n      = pins.sel_n;
  assign fuse_strobe     = pins.strobe;
  assign fuse_load       = pins.load;
  assign fuse_prog_n     = pins.prog_n;
  assign fuse_pwrdn      = pins.pwrdn;
  assign fuse_sense_n    = pins.sense_n;
  assign fuse_strb_shift = pins.strb_shift;
  assign fuse_addr       = pins.addr;

endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk #(
  parameter int WORDS  = 32,
  parameter int BUDGET = 500
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        start_req,
  input logic        ctrl_wr,
  input logic        clr_req,
  input logic        done_pulse,
  input logic        done_flag,
  input logic        in_standby,
  input logic [9:0]  auto_addr,
  input logic [31:0] ctrl_q,
  input logic        fuse_sel_n,
  input logic        fuse_strobe,
  input logic        fuse_load,
  input logic        fuse_prog_n,
  input logic        fuse_pwrdn,
  input logic        fuse_sense_n,
  input logic        fuse_strb_shift,
  input logic [9:0]  fuse_addr
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  // R5: auto strobe only with the macro selected, loaded and powered
  a_r5_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fuse_strobe |-> !fuse_sel_n && fuse_load && fuse_prog_n && !fuse_pwrdn);

  // R10: never strobe outside the array
  a_r10_no_strobe_oob: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fuse_strobe |-> int'(fuse_addr) < WORDS);

  // R8: a start while busy leaves the latched address alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_req |=> $stable(auto_addr));

  // R9: control writes while busy are dropped
  a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_wr |=> $stable(ctrl_q));

  // R7: finish sets the flag, which then holds until cleared
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_flag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !clr_req |=> done_flag);

  // R11: standby pattern at the end of a sequence
  a_r11_standby_pins: assert property (@(posedge clk) disable iff (!rst_n)
    in_standby |-> fuse_sel_n && fuse_pwrdn && !fuse_strobe && !fuse_load &&
                   !fuse_prog_n && !fuse_sense_n && !fuse_strb_shift && fuse_addr == 10'd0);

  // R6: a run ends within the time budget
  a_r6_budget: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 16'(BUDGET));

endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.WORDS(WORDS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (seq_busy),
  .start_req       (start_req),
  .ctrl_wr         (ctrl_wr),
  .clr_req         (clr_req),
  .done_pulse      (done_pulse),
  .done_flag       (done_flag),
  .in_standby      (in_standby),
  .auto_addr       (auto_addr),
  .ctrl_q          (ctrl_q),
  .fuse_sel_n      (fuse_sel_n),
  .fuse_strobe     (fuse_strobe),
  .fuse_load       (fuse_load),
  .fuse_prog_n     (fuse_prog_n),
  .fuse_pwrdn      (fuse_pwrdn),
  .fuse_sense_n    (fuse_sense_n),
  .fuse_strb_shift (fuse_strb_shift),
  .fuse_addr       (fuse_addr)
);

// File: tb/fuse_rd_ctrl_test.sv
module fuse_rd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int STRB_CYC   = 6;
  localparam int LIMIT      = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fuse_sel_n, fuse_strobe, fuse_load, fuse_prog_n;
  logic        fuse_pwrdn, fuse_sense_n, fuse_strb_shift;
  logic [9:0]  fuse_addr;
  logic [31:0] fuse_q;

  int checks = 0;
  int errors = 0;
  int strobe_hi = 0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_rd_ctrl #(.STRB_CYC(STRB_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_sel_n(fuse_sel_n), .fuse_strobe(fuse_strobe), .fuse_load(fuse_load),
    .fuse_prog_n(fuse_prog_n), .fuse_pwrdn(fuse_pwrdn), .fuse_sense_n(fuse_sense_n),
    .fuse_strb_shift(fuse_strb_shift), .fuse_addr(fuse_addr), .fuse_q(fuse_q)
  );

  function automatic logic [31:0] fuse_word(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, ~b, 8'h5A, b ^ 8'hC3};
  endfunction

  // Behavioural macro: data valid while selected, loaded and strobed
  assign fuse_q = (fuse_strobe && !fuse_sel_n && fuse_load && !fuse_pwrdn) ?
                  ((int'(fuse_addr) < 32) ? fuse_word(int'(fuse_addr)) : 32'hFFFF_FFFF) : 32'h0;

  always @(negedge clk) if (fuse_strobe) strobe_hi++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_req) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic sb_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    bus_addr = a;
    mon_req  = 1'b1;
    @(negedge clk); #1;
    mon_req  = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n;
    n = 0;
    s = 0;
    while (n < LIMIT + 20 && s[0] !== 1'b1) begin
      peek(8'h18, s);
      n++;
    end
    check(s[0] === 1'b1 && n <= LIMIT, req, 32'(n), 32'(LIMIT));
  endtask

  task automatic pins_standby(input string req);
    logic [16:0] p;
    p = {fuse_sel_n, fuse_strobe, fuse_load, fuse_prog_n, fuse_pwrdn,
         fuse_sense_n, fuse_strb_shift, fuse_addr};
    check(p === {7'b1000100, 10'd0}, req, 32'(p), 32'({7'b1000100, 10'd0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0] p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    pins_standby("R1 pins");
    sb_read(8'h00, 32'h21, "R1 ctrl");
    sb_read(8'h18, 32'h0, "R1 status");
    sb_read(8'h20, 32'h0, "R1 adata");

    // R2 manual pin drive
    wr(8'h00, 32'h0005_028E);
    @(negedge clk);
    p = {fuse_sel_n, fuse_strobe, fuse_load, fuse_prog_n, fuse_pwrdn,
         fuse_sense_n, fuse_strb_shift, fuse_addr};
    check(p === {7'b0111011, 10'd5}, "R2 manual pins", 32'(p), 32'({7'b0111011, 10'd5}));
    // R3 manual data capture
    wr(8'h00, 32'h21);
    pins_standby("R2 back to standby");
    sb_read(8'h04, fuse_word(5), "R3 manual data");
    repeat (3) @(posedge clk);
    sb_read(8'h04, fuse_word(5), "R3 holds without strobe");

    // R5/R6 auto read of word 10
    strobe_hi = 0;
    wr(8'h24, (32'd10 << 16) | 32'h3);
    wait_done("R6 done in budget");
    sb_read(8'h20, fuse_word(10), "R6 auto data");
    check(strobe_hi == STRB_CYC + 1, "R5 strobe width", 32'(strobe_hi), 32'(STRB_CYC + 1));
    sb_read(8'h24, 32'd10 << 16, "R4 addr readback");
    pins_standby("R11 pins after run");

    // R7 sticky and write-one-to-clear
    wr(8'h18, 32'h0);
    sb_read(8'h18, 32'h1, "R7 write 0 keeps flag");
    wr(8'h18, 32'h1);
    sb_read(8'h18, 32'h0, "R7 write 1 clears");

    // R4 partial start codes do nothing
    wr(8'h24, (32'd12 << 16) | 32'h1);
    wr(8'h24, (32'd12 << 16) | 32'h2);
    repeat (30) @(posedge clk);
    sb_read(8'h18, 32'h0, "R4 no start status");
    sb_read(8'h20, fuse_word(10), "R4 no start data");

    // R8 overlapping start ignored
    wr(8'h24, (32'd3 << 16) | 32'h3);
    wr(8'h24, (32'd7 << 16) | 32'h3);
    wait_done("R8 done");
    sb_read(8'h20, fuse_word(3), "R8 first read wins");
    sb_read(8'h24, 32'd3 << 16, "R8 addr kept");
    wr(8'h18, 32'h1);

    // R9 control locked while busy
    wr(8'h24, (32'd9 << 16) | 32'h3);
    wr(8'h00, 32'h0005_028E);
    wait_done("R9 done");
    sb_read(8'h00, 32'h21, "R9 ctrl unchanged");
    pins_standby("R9 pins standby");
    sb_read(8'h20, fuse_word(9), "R9 data");
    wr(8'h18, 32'h1);

    // R10 boundary addresses
    strobe_hi = 0;
    wr(8'h24, (32'd31 << 16) | 32'h3);
    wait_done("R10 addr 31 done");
    sb_read(8'h20, fuse_word(31), "R10 addr 31 data");
    wr(8'h18, 32'h1);
    foreach (exp_q[i]) begin end
    for (int k = 0; k < 2; k++) begin
      int a;
      a = (k == 0) ? 32 : 40;
      strobe_hi = 0;
      wr(8'h24, (32'(a) << 16) | 32'h3);
      wait_done("R10 oob done");
      check(strobe_hi == 0, "R10 no strobe", 32'(strobe_hi), 32'h0);
      sb_read(8'h20, 32'h0, "R10 zero data");
      wr(8'h18, 32'h1);
    end

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule